// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block sits between a logic-level A side and a wired-OR B side and carries a WIDTH-bit word (9 by default) in each direction. Each direction passes through its own hold stage. A two-bit mode code sets each hold stage to pass-through, level-sensitive latch or edge-triggered register. Each direction has its own enable strobe. Data is inverted on every path. A high bit on `a_in` asks the block to pull the matching B line low. The A side reads the inverse of the resolved B level.

The B side is modelled at logic level. `b_pull` is this agent's per-bit pull-down request. `b_ext_pull` carries the pull-downs of every other agent. `b_bus` is the resolved line level: a line is high only when nobody pulls it. The B driver is active only when both of its enables are in their active states. The A side has one enable, which is reported on `a_drv`. `a_out` always carries the value that would be driven, so stored data can be read back. All behaviour is synchronous to `clk`. Both strobes are sampled on that clock.

Top module: `bus_xcvr`

## Requirements
- R1: The mode code `mode[1:0]` selects the hold behaviour: 2'b00 = latch in both directions, 2'b01 = pass-through in both, 2'b10 = register in both, 2'b11 = register A-to-B and latch B-to-A.
- R2: Both paths invert. `b_pull[i]`=1 (line driven low) means the selected A-to-B data bit is 1. `a_out[i]` is the inverse of the selected B-to-A data bit, which is taken from `b_bus`.
- R3: In pass-through, the outputs follow the inputs in the same cycle, with no clock edge in between.
- R4: In latch mode, while the direction's strobe is 0 the output follows the input in the same cycle, and each clock edge stores the input. While the strobe is 1, the output shows the value stored at the last edge where the strobe was 0.
- R5: In register mode, data is captured only at a clock edge where the strobe is 1 and was 0 at the previous edge. The output changes only after that edge.
- R6: The B side drives only when `b_en_hi`=1 and `b_en_lo_n`=0. In the other three combinations `b_pull` is all zeros.
- R7: `a_drv` follows `a_oe`. `a_out` keeps showing the stored or passed value while `a_drv` is 0.
- R8: A hold stage loads and keeps data while its output side is disabled. The data appears once the side is enabled again.
- R9: `b_bus[i]` is 1 only when neither `b_pull[i]` nor `b_ext_pull[i]` is 1. The B-to-A path takes this resolved level.
- R10: Synchronous reset (`rst`=1) clears the A-to-B store so that nothing is pulled. It sets the B-to-A store to the released (high) level, so a held `a_out` reads 0. A strobe already high when reset is released does not count as a rising edge.
- R11: In pass-through the stores track their inputs on every edge. Switching to a holding mode therefore shows the last passed value, and a mode change with no qualifying strobe activity keeps the held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Hold mode code (see R1) |
| ab_le | input | 1 | A-to-B strobe: latch enable (active low) or capture clock |
| ba_le | input | 1 | B-to-A strobe: latch enable (active low) or capture clock |
| a_oe | input | 1 | A side output enable, active high |
| b_en_hi | input | 1 | B side enable, active high |
| b_en_lo_n | input | 1 | B side enable, active low |
| a_in | input | WIDTH | Data arriving from the A side |
| b_ext_pull | input | WIDTH | Pull-down requests from other B agents |
| a_out | output | WIDTH | Value for the A side drivers |
| a_drv | output | 1 | A side drivers enabled |
| b_pull | output | WIDTH | This agent's pull-down request per B line |
| b_bus | output | WIDTH | Resolved B line level (1 = released high) |

## Verification
The bound checker watches five things on every cycle:
- the B driver stays idle whenever its enable pair is not active;
- an externally pulled line never reads high;
- pass-through is combinational in both directions;
- a registered A-to-B output holds across edges with no rising strobe;
- a latched B-to-A output holds while its strobe stays high.

Other behaviour is only shown by the bench scenarios, which it runs against a reference model compared every cycle:
- the exact mode-code mapping;
- the reset edge-arming rule;
- loading data while the B side is disabled;
- the value carried across mode switches.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Per-direction hold behaviour
   typedef enum logic [1:0] {
      HM_PASS  = 2'd0,
      HM_LATCH = 2'd1,
      HM_REG   = 2'd2
   } hold_mode_e;

   typedef struct packed {
      hold_mode_e a2b;
      hold_mode_e b2a;
   } path_modes_t;

   // Mode codes on the mode input (R1)
   localparam logic [1:0] SEL_LATCH_BOTH = 2'b00;
   localparam logic [1:0] SEL_PASS_BOTH  = 2'b01;
   localparam logic [1:0] SEL_REG_BOTH   = 2'b10;
   localparam logic [1:0] SEL_SPLIT      = 2'b11;

endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
   import xcvr_pkg::*;
(
   input  logic [1:0]  sel,
   output path_modes_t modes
);

   // R1: mode code to per-direction hold behaviour
   always_comb begin
      modes.a2b = HM_LATCH;
      modes.b2a = HM_LATCH;
      unique case (sel)
         SEL_LATCH_BOTH: begin
            modes.a2b = HM_LATCH;
            modes.b2a = HM_LATCH;
         end
         SEL_PASS_BOTH: begin
            modes.a2b = HM_PASS;
            modes.b2a = HM_PASS;
         end
         SEL_REG_BOTH: begin
            modes.a2b = HM_REG;
            modes.b2a = HM_REG;
         end
         SEL_SPLIT: begin
            modes.a2b = HM_REG;
            modes.b2a = HM_LATCH;
         end
         default: begin
            modes.a2b = HM_LATCH;
            modes.b2a = HM_LATCH;
         end
      endcase
   end

endmodule

// File: rtl/xcvr_hold_stage.sv
module xcvr_hold_stage
   import xcvr_pkg::*;
#(
   parameter int WIDTH      = 9,
   parameter bit RST_ONES   = 1'b0,
   parameter bit INVERT_OUT = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  hold_mode_e       mode,
   input  logic             le,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_ONES}};

   logic [WIDTH-1:0] store_q;
   logic             le_q;
   logic             rise;
   logic             load;
   logic             transparent;
   logic [WIDTH-1:0] sel_val;

   // R5: rising strobe seen between two clock edges
   assign rise = le & ~le_q;

   // R4/R5/R11: when the store takes new data
   always_comb begin
      unique case (mode)
         HM_PASS:  load = 1'b1;
         HM_LATCH: load = ~le;
         HM_REG:   load = rise;
         default:  load = 1'b0;
      endcase
   end

   // R10: reset arms the edge detector high so a held strobe is no edge
   always_ff @(posedge clk) begin
      if (rst) begin
         store_q <= RST_VEC;
         le_q    <= 1'b1;
      end else begin
         le_q <= le;
         if (load) store_q <= d;
      end
   end

   // R3/R4: pass-through and open latch are combinational
   assign transparent = (mode == HM_PASS) || ((mode == HM_LATCH) && !le);
   assign sel_val     = transparent ? d : store_q;

   generate
      if (INVERT_OUT) begin : g_inv
         assign q = ~sel_val;
      end else begin : g_true
         assign q = sel_val;
      end
   endgenerate

endmodule

// File: rtl/xcvr_b_port.sv
module xcvr_b_port #(
   parameter int WIDTH = 9
)(
   input  logic             en_hi,
   input  logic             en_lo_n,
   input  logic [WIDTH-1:0] pull_req,
   input  logic [WIDTH-1:0] ext_pull,
   output logic [WIDTH-1:0] pull_out,
   output logic [WIDTH-1:0] bus_lvl
);

   logic drive;

   // R6: both enables must be active
   assign drive = en_hi & ~en_lo_n;

   // R9: per-line wired resolution, pulled-up when nobody pulls
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_line
         assign pull_out[i] = pull_req[i] & drive;
         assign bus_lvl[i]  = ~(pull_out[i] | ext_pull[i]);
      end
   endgenerate

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 9
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic             ab_le,
   input  logic             ba_le,
   input  logic             a_oe,
   input  logic             b_en_hi,
   input  logic             b_en_lo_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_ext_pull,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   output logic [WIDTH-1:0] b_pull,
   output logic [WIDTH-1:0] b_bus
);

   initial begin
      assert (WIDTH >= 1) else $error("bus_xcvr: WIDTH must be at least 1");
   end

   path_modes_t      modes;
   logic [WIDTH-1:0] ab_req;
   logic [WIDTH-1:0] bus_lvl;

   xcvr_mode_dec u_dec (
      .sel   (mode),
      .modes (modes)
   );

   // A-to-B: a 1 on A becomes a pull-down request (R2)
   xcvr_hold_stage #(
      .WIDTH      (WIDTH),
      .RST_ONES   (1'b0),
      .INVERT_OUT (1'b0)
   ) u_ab (
      .clk  (clk),
      .rst  (rst),
      .mode (modes.a2b),
      .le   (ab_le),
      .d    (a_in),
      .q    (ab_req)
   );

   xcvr_b_port #(
      .WIDTH (WIDTH)
   ) u_bport (
      .en_hi    (b_en_hi),
      .en_lo_n  (b_en_lo_n),
      .pull_req (ab_req),
      .ext_pull (b_ext_pull),
      .pull_out (b_pull),
      .bus_lvl  (bus_lvl)
   );

   // B-to-A: store the resolved level, present its inverse (R2, R9, R10)
   xcvr_hold_stage #(
      .WIDTH      (WIDTH),
      .RST_ONES   (1'b1),
      .INVERT_OUT (1'b1)
   ) u_ba (
      .clk  (clk),
      .rst  (rst),
      .mode (modes.b2a),
      .le   (ba_le),
      .d    (bus_lvl),
      .q    (a_out)
   );

   assign b_bus = bus_lvl;
   assign a_drv = a_oe;   // R7

endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
   parameter int WIDTH = 9
)(
   input logic             clk,
   input logic             rst,
   input logic [1:0]       mode,
   input logic             ab_le,
   input logic             ba_le,
   input logic             b_en_hi,
   input logic             b_en_lo_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_ext_pull,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] b_pull,
   input logic [WIDTH-1:0] b_bus
);

   logic drv_on;
   logic is_pass;
   logic ab_is_reg;
   logic ba_is_latch;

   assign drv_on      = b_en_hi && !b_en_lo_n;
   assign is_pass     = (mode == 2'b01);
   assign ab_is_reg   = (mode == 2'b10) || (mode == 2'b11);
   assign ba_is_latch = (mode == 2'b00) || (mode == 2'b11);

   p_b_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !drv_on |-> (b_pull == '0));

   p_ext_low_r9: assert property (@(posedge clk) disable iff (rst)
      ((b_ext_pull & b_bus) == '0));

   p_pass_ab_r3: assert property (@(posedge clk) disable iff (rst)
      (is_pass && drv_on) |-> (b_pull == a_in));

   p_pass_ba_r2: assert property (@(posedge clk) disable iff (rst)
      is_pass |-> (a_out == ~b_bus));

   p_reg_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (ab_is_reg && drv_on && !$rose(ab_le)) |=>
      (!(ab_is_reg && drv_on) || $stable(b_pull)));

   p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (ba_is_latch && ba_le) |=>
      (!(ba_is_latch && ba_le) || $stable(a_out)));

   p_reset_state_r10: assert property (@(posedge clk)
      (!rst && $past(rst) && mode == 2'b10) |-> (b_pull == '0 && a_out == '0));

endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mode       (mode),
   .ab_le      (ab_le),
   .ba_le      (ba_le),
   .b_en_hi    (b_en_hi),
   .b_en_lo_n  (b_en_lo_n),
   .a_in       (a_in),
   .b_ext_pull (b_ext_pull),
   .a_out      (a_out),
   .b_pull     (b_pull),
   .b_bus      (b_bus)
);

// File: tb/bus_xcvr_tb.sv
`timescale 1ns/1ps
module bus_xcvr_tb;

   localparam int W = 9;
   localparam logic [W-1:0] ONES = '1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst = 1'b1;
   logic [1:0]   mode = 2'b10;
   logic         ab_le = 1'b1, ba_le = 1'b0;
   logic         a_oe = 1'b1, b_en_hi = 1'b1, b_en_lo_n = 1'b0;
   logic [W-1:0] a_in = 9'h0F3, b_ext_pull = '0;
   logic [W-1:0] a_out, b_pull, b_bus;
   logic         a_drv;

   bus_xcvr #(.WIDTH(W)) u_dut (
      .clk(clk), .rst(rst), .mode(mode), .ab_le(ab_le), .ba_le(ba_le),
      .a_oe(a_oe), .b_en_hi(b_en_hi), .b_en_lo_n(b_en_lo_n),
      .a_in(a_in), .b_ext_pull(b_ext_pull),
      .a_out(a_out), .a_drv(a_drv), .b_pull(b_pull), .b_bus(b_bus)
   );

   int    n_run = 0, n_fail = 0;
   bit    done = 1'b0;
   string req = "R10";

   // reference model state
   logic [W-1:0] m_ab, m_ba;
   logic         m_abp, m_bap;

   // 0 = pass, 1 = latch, 2 = register
   function automatic int kind(logic [1:0] md, bit b2a);
      int k;
      case (md)
         2'b00:   k = 1;
         2'b01:   k = 0;
         2'b10:   k = 2;
         default: k = b2a ? 1 : 2;
      endcase
      return k;
   endfunction

   function automatic logic [W-1:0] m_pull();
      logic [W-1:0] v;
      int k = kind(mode, 1'b0);
      v = (k == 0 || (k == 1 && !ab_le)) ? a_in : m_ab;
      return (b_en_hi && !b_en_lo_n) ? v : '0;
   endfunction

   function automatic logic [W-1:0] m_bus();
      return ~(m_pull() | b_ext_pull);
   endfunction

   function automatic logic [W-1:0] m_a();
      int k = kind(mode, 1'b1);
      return ~((k == 0 || (k == 1 && !ba_le)) ? m_bus() : m_ba);
   endfunction

   task automatic chk(string r, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(req, "b_pull", b_pull, m_pull());
      chk(req, "b_bus",  b_bus,  m_bus());
      chk(req, "a_out",  a_out,  m_a());
      chk(req, "a_drv",  {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, a_oe});
   endtask

   task automatic update();
      logic [W-1:0] bus;
      int k;
      if (rst) begin
         m_ab = '0; m_ba = ONES; m_abp = 1'b1; m_bap = 1'b1;
      end else begin
         bus = m_bus();
         k = kind(mode, 1'b0);
         if (k == 0 || (k == 1 && !ab_le) || (k == 2 && ab_le && !m_abp)) m_ab = a_in;
         k = kind(mode, 1'b1);
         if (k == 0 || (k == 1 && !ba_le) || (k == 2 && ba_le && !m_bap)) m_ba = bus;
         m_abp = ab_le; m_bap = ba_le;
      end
   endtask

   task automatic sample(); @(negedge clk); #1; compare(); endtask
   task automatic edge_(); @(posedge clk); #1; update(); endtask
   task automatic cyc(); sample(); edge_(); endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // reset with A-to-B strobe held high (R10 edge arming)
      repeat (3) edge_();
      rst = 1'b0;
      req = "R10";
      sample();
      chk("R10", "b_pull after reset", b_pull, '0);
      chk("R10", "a_out after reset", a_out, '0);
      chk("R10", "b_bus after reset", b_bus, ONES);
      edge_();
      sample();
      chk("R10", "no capture on held strobe", b_pull, '0);
      edge_();

      // register mode (R5)
      req = "R5";
      ab_le = 1'b0; cyc();
      ab_le = 1'b1; sample();
      chk("R5", "before capture edge", b_pull, '0);
      edge_();
      sample();
      chk("R5", "after capture edge", b_pull, 9'h0F3);
      edge_();
      a_in = 9'h100; cyc(); sample();
      chk("R5", "no capture while high", b_pull, 9'h0F3);
      edge_();
      ab_le = 1'b0; a_in = 9'h0AB; cyc();
      ba_le = 1'b1; cyc(); sample();
      chk("R2", "B-to-A loopback inverted", a_out, 9'h0F3);
      edge_();

      // pass-through (R3, R2, R9)
      mode = 2'b01; ab_le = 1'b0; ba_le = 1'b0;
      req = "R3"; a_in = 9'h1A5; sample();
      chk("R3", "pull same cycle", b_pull, 9'h1A5);
      chk("R2", "bus inverted", b_bus, 9'h05A);
      chk("R3", "a_out same cycle", a_out, 9'h1A5);
      edge_();
      req = "R9"; b_ext_pull = 9'h003; sample();
      chk("R9", "wired resolution", b_bus, 9'h058);
      chk("R9", "A reads resolved", a_out, 9'h1A7);
      edge_();
      b_ext_pull = '0;

      // B enable combinations (R6)
      req = "R6"; a_in = ONES;
      for (int c = 0; c < 4; c++) begin
         b_en_hi = c[1]; b_en_lo_n = c[0];
         sample();
         chk("R6", "enable pair", b_pull, (c == 2) ? ONES : '0);
         edge_();
      end
      b_en_hi = 1'b1; b_en_lo_n = 1'b0;

      // latch both (R4)
      mode = 2'b00; req = "R4"; ab_le = 1'b0; a_in = 9'h055; sample();
      chk("R4", "transparent", b_pull, 9'h055);
      edge_();
      ab_le = 1'b1; a_in = 9'h0AA; sample();
      chk("R4", "held after close", b_pull, 9'h055);
      edge_();
      a_in = 9'h000; cyc(); cyc();
      ab_le = 1'b0; sample();
      chk("R4", "reopened", b_pull, 9'h000);
      edge_();
      ba_le = 1'b0; b_ext_pull = 9'h011; sample();
      chk("R4", "B-to-A transparent", a_out, 9'h011);
      edge_();
      ba_le = 1'b1; b_ext_pull = 9'h022; sample();
      chk("R4", "B-to-A held", a_out, 9'h011);
      edge_();
      b_ext_pull = '0; ba_le = 1'b0;

      // loading while disabled (R8, R7)
      mode = 2'b10; req = "R8"; b_en_hi = 1'b0; a_in = 9'h12C; ab_le = 1'b0; cyc();
      ab_le = 1'b1; cyc(); sample();
      chk("R8", "disabled side idle", b_pull, '0);
      edge_();
      b_en_hi = 1'b1; sample();
      chk("R8", "loaded data appears", b_pull, 9'h12C);
      edge_();
      req = "R7"; a_oe = 1'b0; sample();
      chk("R7", "a_drv off", {{(W-1){1'b0}}, a_drv}, '0);
      chk("R7", "a_out kept", a_out, m_a());
      edge_();
      a_oe = 1'b1;

      // mode switches while holding (R11, R1)
      req = "R11"; mode = 2'b01; a_in = 9'h0C3; cyc();
      mode = 2'b00; a_in = 9'h03C; sample();
      chk("R11", "latch after pass", b_pull, 9'h0C3);
      edge_();
      mode = 2'b10; cyc(); sample();
      chk("R11", "register after latch", b_pull, 9'h0C3);
      edge_();
      req = "R1"; mode = 2'b11; ba_le = 1'b0; sample();
      chk("R1", "split: A-to-B registered", b_pull, 9'h0C3);
      chk("R1", "split: B-to-A latch open", a_out, ~b_bus);
      edge_();

      // random stress against the model (R1)
      req = "R1";
      for (int n = 0; n < 400; n++) begin
         mode = 2'($urandom); ab_le = 1'($urandom); ba_le = 1'($urandom);
         a_oe = 1'($urandom); b_en_hi = ($urandom % 4) != 0; b_en_lo_n = ($urandom % 4) == 0;
         a_in = W'($urandom); b_ext_pull = ($urandom % 2) ? W'($urandom) : '0;
         cyc();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule